// File: doc/BRIEF.md
# Static Memory Strobe Timing Generator

This block drives the control strobes of an asynchronous static memory, such as a parallel flash device. A single access request, either a read or a write, becomes a chip-select window. Output-enable or write-enable goes low inside that window at a programmed offset. Every timing figure is a small code on a static configuration input. Each code is converted into a count of system clock cycles, and each field has its own offset rule. After every access the block keeps chip-select high for a programmed bus turnaround gap before another access may begin.

The requester raises `req_start` for one cycle and presents the direction, address and write data with it. The block returns a one-cycle `done` pulse. For a read, `rdata` holds the word captured on the last cycle of the read. A start that arrives during the turnaround gap is kept in a one-entry slot and launched as soon as the gap ends. The timing codes and the request fields are captured when an access launches, so the inputs may change while the access is in progress.

Top module: `smem_timing_gen`

## Requirements
- R1: After reset `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high (all strobes are active low), `mem_wdata_en` is low and `done` is low.
- R2: For a read, chip-select stays low for `cfg_rd_len`+1 cycles. Output-enable goes low `cfg_oe_lead` cycles after chip-select falls, or on the last chip-select cycle if that offset does not fit. It stays low until chip-select rises. Write-enable stays high throughout.
- R3: For a write, chip-select stays low for `cfg_wr_len`+2 cycles. Write-enable goes low 1 cycle after chip-select falls when `cfg_we_lead` is 0, and `cfg_we_lead`+1 cycles after otherwise. It is moved to the last chip-select cycle if the offset does not fit. It stays low until chip-select rises. Output-enable stays high, and `mem_wdata_en` is high exactly while chip-select is low.
- R4: The reserved top codes are clamped to the largest valid code: 31 on `cfg_rd_len` or `cfg_wr_len` acts as 30, and 15 on `cfg_turn` acts as 14.
- R5: A read samples `mem_rdata` on its last chip-select cycle. That value appears on `rdata` from the `done` cycle onward.
- R6: `done` is high for exactly one cycle, the first cycle in which chip-select is high again after an access, and it is low at all other times.
- R7: After each access, chip-select stays high for at least `cfg_turn`+1 cycles (the value captured for that access). A start issued at cycle d after the `done` cycle makes chip-select fall at cycle max(turn+1, d+1).
- R8: A start that arrives during turnaround is held and launched with its own direction, address and data when the gap ends. Further starts while one is held are ignored.
- R9: A start that arrives while chip-select is low is ignored and launches no access.
- R10: The timing codes are captured when an access launches, and so are the request fields for an immediate launch. Changes on those inputs afterwards have no effect on the access in progress: `mem_addr` and `mem_wdata` stay steady while chip-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all wait counts are in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | One-cycle access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| cfg_we_lead | input | WE_W | Chip-select to write-enable delay code |
| cfg_oe_lead | input | OE_W | Chip-select to output-enable delay code |
| cfg_rd_len | input | RD_W | Read cycle length code |
| cfg_wr_len | input | WR_W | Write access length code |
| cfg_turn | input | TURN_W | Bus turnaround code |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last read word |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_wdata | output | DATA_W | Write data to the memory |
| mem_wdata_en | output | 1 | Data bus drive enable during writes |
| mem_rdata | input | DATA_W | Read data from the memory |

## Verification
The embedded assertions watch these properties on every cycle:
- the enables are never low outside chip-select, and output-enable and write-enable are never low together;
- write-enable is still low in the last write cycle, and output-enable is low on the read sample cycle;
- the access counter stays inside the captured length, and `done` is a single cycle;
- address and data are steady under chip-select, and a held request survives until it launches;
- the high gap before each falling chip-select covers the captured turnaround.

Only the bench scenarios can show the exact cycle counts for each code: the offset rules, the clamps, the fall cycle as a function of how late a start arrives, and that ignored starts leave no trace. The bench checks them against its own arithmetic over directed corner codes and seeded random traffic.

// File: rtl/smem_pkg.sv
`timescale 1ns/1ps
package smem_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_TURN} smem_state_e;

  // Recommended power-up codes for the timing fields.
  localparam int DEF_WE_CODE   = 0;
  localparam int DEF_OE_CODE   = 0;
  localparam int DEF_RD_CODE   = 10;
  localparam int DEF_WR_CODE   = 7;
  localparam int DEF_TURN_CODE = 2;

  // Top code of a field is reserved: fold it onto the one below.
  function automatic int clamp_code(input int code, input int width);
    int top;
    top = (1 << width) - 1;
    return (code >= top) ? top - 1 : code;
  endfunction

  function automatic int rd_cycles(input int code);
    return code + 1;
  endfunction

  function automatic int wr_cycles(input int code);
    return code + 2;
  endfunction

  // Zero still leaves one cycle between chip-select and write-enable.
  function automatic int we_lead(input int code);
    return (code == 0) ? 1 : code + 1;
  endfunction

  function automatic int oe_lead(input int code);
    return code;
  endfunction

  function automatic int turn_cycles(input int code);
    return code + 1;
  endfunction

  // Enable must be low at least on the last chip-select cycle.
  function automatic int strobe_start(input int lead, input int len);
    return (lead >= len) ? len - 1 : lead;
  endfunction

endpackage

// File: rtl/smem_req_hold.sv
`timescale 1ns/1ps
module smem_req_hold #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              in_turn,
  input  logic              take,
  output logic              hold_valid,
  output logic              src_write,
  output logic [ADDR_W-1:0] src_addr,
  output logic [DATA_W-1:0] src_wdata
);

  logic              h_write;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_wdata;
  logic              capture;

  // Only the first start of a turnaround gap is kept.
  assign capture = req_start && in_turn && !hold_valid && !take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      h_write    <= 1'b0;
      h_addr     <= '0;
      h_wdata    <= '0;
    end else if (take) begin
      hold_valid <= 1'b0;
    end else if (capture) begin
      hold_valid <= 1'b1;
      h_write    <= req_write;
      h_addr     <= req_addr;
      h_wdata    <= req_wdata;
    end
  end

  assign src_write = hold_valid ? h_write : req_write;
  assign src_addr  = hold_valid ? h_addr  : req_addr;
  assign src_wdata = hold_valid ? h_wdata : req_wdata;

  // R8: a held request is kept unchanged until it is launched
  p_hold_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && !take) |=> (hold_valid && $stable(h_addr) && $stable(h_write)));

  p_hold_only_turn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_valid) |-> $past(in_turn));

endmodule

// File: rtl/smem_timing_snap.sv
`timescale 1ns/1ps
module smem_timing_snap import smem_pkg::*; #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int WE_W   = 4,
  parameter int OE_W   = 4,
  parameter int RD_W   = 5,
  parameter int WR_W   = 5,
  parameter int TURN_W = 4,
  parameter int CNT_W  = 6,
  parameter int TCW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              src_write,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_wdata,
  input  logic [WE_W-1:0]   cfg_we_lead,
  input  logic [OE_W-1:0]   cfg_oe_lead,
  input  logic [RD_W-1:0]   cfg_rd_len,
  input  logic [WR_W-1:0]   cfg_wr_len,
  input  logic [TURN_W-1:0] cfg_turn,
  output logic              wr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [CNT_W-1:0]  len_q,
  output logic [CNT_W-1:0]  on_q,
  output logic [TCW-1:0]    turn_q
);

  localparam int MAX_LEN = (((1 << RD_W) - 1) > (1 << WR_W)) ? ((1 << RD_W) - 1) : (1 << WR_W);
  localparam int RST_LEN = rd_cycles(DEF_RD_CODE);

  logic [CNT_W-1:0] len_n;
  logic [CNT_W-1:0] on_n;
  logic [TCW-1:0]   turn_n;

  always_comb begin
    int rd_c;
    int wr_c;
    int tu_c;
    int len_i;
    int lead_i;
    rd_c   = clamp_code(int'(cfg_rd_len), RD_W);
    wr_c   = clamp_code(int'(cfg_wr_len), WR_W);
    tu_c   = clamp_code(int'(cfg_turn), TURN_W);
    len_i  = src_write ? wr_cycles(wr_c) : rd_cycles(rd_c);
    lead_i = src_write ? we_lead(int'(cfg_we_lead)) : oe_lead(int'(cfg_oe_lead));
    len_n  = CNT_W'(len_i);
    on_n   = CNT_W'(strobe_start(lead_i, len_i));
    turn_n = TCW'(turn_cycles(tu_c));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      len_q   <= CNT_W'(RST_LEN);
      on_q    <= CNT_W'(strobe_start(oe_lead(DEF_OE_CODE), RST_LEN));
      turn_q  <= TCW'(turn_cycles(DEF_TURN_CODE));
    end else if (load) begin
      wr_q    <= src_write;
      addr_q  <= src_addr;
      wdata_q <= src_wdata;
      len_q   <= len_n;
      on_q    <= on_n;
      turn_q  <= turn_n;
    end
  end

  // R3: the enable start always lies inside the chip-select window
  p_on_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    on_q < len_q);

  // R4: a clamped code never yields a window beyond the longest valid one
  p_len_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(len_q) <= MAX_LEN) && (int'(turn_q) <= (1 << TURN_W) - 1));

endmodule

// File: rtl/smem_access_fsm.sv
`timescale 1ns/1ps
module smem_access_fsm import smem_pkg::*; #(
  parameter int CNT_W = 6,
  parameter int TCW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic             hold_valid,
  input  logic [CNT_W-1:0] len_q,
  input  logic [TCW-1:0]   turn_q,
  output logic             go,
  output logic             in_acc,
  output logic             in_turn,
  output logic             acc_last,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);

  smem_state_e    st;
  smem_state_e    st_n;
  logic [TCW-1:0] tcnt;
  logic           turn_last;

  assign in_acc    = (st == ST_ACC);
  assign in_turn   = (st == ST_TURN);
  assign acc_last  = in_acc && (cnt == len_q - CNT_W'(1));
  assign turn_last = in_turn && (tcnt == turn_q - TCW'(1));
  assign go        = ((st == ST_IDLE) && req_start) ||
                     (turn_last && (hold_valid || req_start));

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE: if (go) st_n = ST_ACC;
      ST_ACC:  if (acc_last) st_n = ST_TURN;
      ST_TURN: if (turn_last) st_n = go ? ST_ACC : ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      tcnt <= '0;
      done <= 1'b0;
    end else begin
      st   <= st_n;
      done <= acc_last;
      if (go)
        cnt <= '0;
      else if (in_acc && !acc_last)
        cnt <= cnt + CNT_W'(1);
      if (acc_last)
        tcnt <= '0;
      else if (in_turn)
        tcnt <= tcnt + TCW'(1);
    end
  end

  // R2: the access counter never passes the captured length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_acc |-> (cnt < len_q));

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: completion coincides with leaving the access window
  p_done_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(in_acc) && !in_acc));

endmodule

// File: rtl/smem_strobe_drv.sv
`timescale 1ns/1ps
module smem_strobe_drv #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6,
  parameter int TCW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_acc,
  input  logic              acc_last,
  input  logic              wr_q,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  on_q,
  input  logic [TCW-1:0]    turn_q,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_wdata_en,
  output logic [DATA_W-1:0] rdata
);

  logic reached;

  assign reached      = in_acc && (cnt >= on_q);
  assign mem_cs_n     = !in_acc;
  assign mem_oe_n     = !(reached && !wr_q);
  assign mem_we_n     = !(reached && wr_q);
  assign mem_wdata_en = in_acc && wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (acc_last && !wr_q)
      rdata <= mem_rdata;
  end

  // Gap watcher for the turnaround property: counts high chip-select cycles.
  logic [TCW-1:0] chk_gap;
  logic [TCW-1:0] chk_turn;
  logic           chk_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_gap  <= '0;
      chk_turn <= '0;
      chk_seen <= 1'b0;
    end else begin
      if (!mem_cs_n)
        chk_gap <= '0;
      else if (chk_gap != '1)
        chk_gap <= chk_gap + TCW'(1);
      if (acc_last) begin
        chk_turn <= turn_q;
        chk_seen <= 1'b1;
      end
    end
  end

  // R7: each new chip-select fall respects the previous turnaround
  p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_cs_n) && chk_seen) |-> (chk_gap >= chk_turn));

  // R2: output-enable only inside chip-select
  p_oe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_cs_n);

  // R3: write-enable only inside chip-select
  p_we_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  // R2: the two enables never overlap
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R3: write-enable is still low on the last write cycle
  p_we_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_cs_n) && $past(wr_q)) |-> $past(!mem_we_n));

  // R5: the read sample cycle has output-enable low
  p_oe_at_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_last && !wr_q) |-> !mem_oe_n);

endmodule

// File: rtl/smem_timing_gen.sv
`timescale 1ns/1ps
module smem_timing_gen #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int WE_W   = 4,
  parameter int OE_W   = 4,
  parameter int RD_W   = 5,
  parameter int WR_W   = 5,
  parameter int TURN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [WE_W-1:0]   cfg_we_lead,
  input  logic [OE_W-1:0]   cfg_oe_lead,
  input  logic [RD_W-1:0]   cfg_rd_len,
  input  logic [WR_W-1:0]   cfg_wr_len,
  input  logic [TURN_W-1:0] cfg_turn,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdata_en,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int MAX_LEN = (((1 << RD_W) - 1) > (1 << WR_W)) ? ((1 << RD_W) - 1) : (1 << WR_W);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int TCW     = TURN_W;

  logic              go, in_acc, in_turn, acc_last;
  logic              hold_valid, src_write, wr_q;
  logic [ADDR_W-1:0] src_addr;
  logic [DATA_W-1:0] src_wdata;
  logic [CNT_W-1:0]  cnt, len_q, on_q;
  logic [TCW-1:0]    turn_q;

  smem_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .in_turn(in_turn), .take(go),
    .hold_valid(hold_valid), .src_write(src_write), .src_addr(src_addr),
    .src_wdata(src_wdata)
  );

  smem_timing_snap #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_W(WE_W), .OE_W(OE_W), .RD_W(RD_W),
    .WR_W(WR_W), .TURN_W(TURN_W), .CNT_W(CNT_W), .TCW(TCW)
  ) u_snap (
    .clk(clk), .rst_n(rst_n), .load(go), .src_write(src_write),
    .src_addr(src_addr), .src_wdata(src_wdata), .cfg_we_lead(cfg_we_lead),
    .cfg_oe_lead(cfg_oe_lead), .cfg_rd_len(cfg_rd_len), .cfg_wr_len(cfg_wr_len),
    .cfg_turn(cfg_turn), .wr_q(wr_q), .addr_q(mem_addr), .wdata_q(mem_wdata),
    .len_q(len_q), .on_q(on_q), .turn_q(turn_q)
  );

  smem_access_fsm #(.CNT_W(CNT_W), .TCW(TCW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .hold_valid(hold_valid),
    .len_q(len_q), .turn_q(turn_q), .go(go), .in_acc(in_acc), .in_turn(in_turn),
    .acc_last(acc_last), .done(done), .cnt(cnt)
  );

  smem_strobe_drv #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TCW(TCW)) u_drv (
    .clk(clk), .rst_n(rst_n), .in_acc(in_acc), .acc_last(acc_last), .wr_q(wr_q),
    .cnt(cnt), .on_q(on_q), .turn_q(turn_q), .mem_rdata(mem_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_wdata_en(mem_wdata_en), .rdata(rdata)
  );

  // R10: address and write data are steady across the chip-select window
  p_addr_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

  // R9: no access starts while chip-select is already low
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($past(cnt) != cnt || len_q == CNT_W'(1)));

endmodule

// File: tb/smem_timing_gen_bench.sv
`timescale 1ns/1ps
module smem_timing_gen_bench;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_start = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [3:0]        cfg_we_lead = '0;
  logic [3:0]        cfg_oe_lead = '0;
  logic [4:0]        cfg_rd_len = '0;
  logic [4:0]        cfg_wr_len = '0;
  logic [3:0]        cfg_turn = '0;
  logic              done;
  logic [DATA_W-1:0] rdata;
  logic              mem_cs_n, mem_oe_n, mem_we_n, mem_wdata_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  int prev_t = 0;
  bit last_poke  = 1'b0;
  bit last_extra = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] x);
    return DATA_W'(x * 7) ^ DATA_W'(16'hA55A);
  endfunction

  // Memory model: drives a known word only while output-enable is low.
  assign mem_rdata = !mem_oe_n ? pat(mem_addr) : '1;

  smem_timing_gen u_smem_timing_gen (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg_we_lead(cfg_we_lead),
    .cfg_oe_lead(cfg_oe_lead), .cfg_rd_len(cfg_rd_len), .cfg_wr_len(cfg_wr_len),
    .cfg_turn(cfg_turn), .done(done), .rdata(rdata), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wdata_en(mem_wdata_en), .mem_rdata(mem_rdata)
  );

  // Expected-value arithmetic, written from the requirements.
  function automatic int e_len(input bit wr, input int crd, input int cwr);
    if (wr) return ((cwr == 31) ? 30 : cwr) + 2;
    return ((crd == 31) ? 30 : crd) + 1;
  endfunction

  function automatic int e_on(input bit wr, input int cwe, input int coe, input int len);
    int lead;
    lead = wr ? ((cwe == 0) ? 1 : cwe + 1) : coe;
    return (lead > len - 1) ? len - 1 : lead;
  endfunction

  function automatic int e_turn(input int ctu);
    return ((ctu == 15) ? 14 : ctu) + 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_one(input bit wr, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] dat, input int cwe, input int coe,
                         input int crd, input int cwr, input int ctu, input int d,
                         input bit poke, input bit extra, input string tag);
    int  len, on, exp_fall, c;
    bit  held, extra_ok, fell, wave_bad, snap_bad, done_bad;
    string gtag;
    len      = e_len(wr, crd, cwr);
    on       = e_on(wr, cwe, coe, len);
    exp_fall = (d + 1 > prev_t) ? d + 1 : prev_t;
    held     = (d <= prev_t - 2);
    extra_ok = extra && held;
    gtag     = last_extra ? "R8" : (last_poke ? "R9" : (held ? "R8" : "R7"));
    repeat (d) @(negedge clk);
    cfg_we_lead = 4'(cwe); cfg_oe_lead = 4'(coe); cfg_rd_len = 5'(crd);
    cfg_wr_len = 5'(cwr); cfg_turn = 4'(ctu);
    req_write = wr; req_addr = a; req_wdata = dat; req_start = 1'b1;
    c = d; fell = 1'b0;
    while (!fell && c < d + 200) begin
      @(negedge clk);
      c++;
      if (!mem_cs_n) fell = 1'b1;
      if (c == d + 1) begin
        req_addr = ~a; req_wdata = ~dat; req_write = ~wr;
        req_start = extra_ok;
      end else begin
        req_start = 1'b0;
      end
    end
    check(fell && c == exp_fall, gtag, "chip-select fall cycle", c, exp_fall);
    if (!fell) return;
    wave_bad = 1'b0; snap_bad = 1'b0; done_bad = 1'b0;
    for (int k = 0; k <= len; k++) begin
      if (k > 0) @(negedge clk);
      if (k < len) begin
        if (mem_cs_n !== 1'b0) wave_bad = 1'b1;
        if (mem_oe_n !== ((!wr && k >= on) ? 1'b0 : 1'b1)) wave_bad = 1'b1;
        if (mem_we_n !== ((wr && k >= on) ? 1'b0 : 1'b1)) wave_bad = 1'b1;
        if (mem_wdata_en !== wr) wave_bad = 1'b1;
        if (mem_addr !== a) snap_bad = 1'b1;
        if (wr && mem_wdata !== dat) snap_bad = 1'b1;
        if (done !== 1'b0) done_bad = 1'b1;
      end else begin
        if (mem_cs_n !== 1'b1 || mem_oe_n !== 1'b1 || mem_we_n !== 1'b1 ||
            mem_wdata_en !== 1'b0) wave_bad = 1'b1;
        if (done !== 1'b1) done_bad = 1'b1;
      end
      if (k == 0) begin
        // Inputs change under a live access; a start here must be ignored.
        cfg_we_lead = 4'($urandom); cfg_oe_lead = 4'($urandom);
        cfg_rd_len = 5'($urandom); cfg_wr_len = 5'($urandom); cfg_turn = 4'($urandom);
        req_addr = a ^ 1; req_start = poke;
      end else begin
        req_start = 1'b0;
      end
    end
    check(!wave_bad, tag, wr ? "write strobe waveform" : "read strobe waveform",
          wave_bad, 0);
    check(!snap_bad, "R10", "address/data steady at launch values", mem_addr, a);
    check(!done_bad, "R6", "done only in first cycle after access", done, 1);
    if (!wr) check(rdata === pat(a), "R5", "read data", rdata, pat(a));
    prev_t     = e_turn(ctu);
    last_poke  = poke;
    last_extra = extra_ok;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset values
    check(mem_cs_n === 1'b1 && mem_oe_n === 1'b1 && mem_we_n === 1'b1,
          "R1", "strobes high in reset", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
    check(done === 1'b0 && mem_wdata_en === 1'b0, "R1", "done/enable low in reset",
          {done, mem_wdata_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_cs_n === 1'b1 && done === 1'b0, "R1", "idle after reset",
          {mem_cs_n, done}, 2'b10);

    // Directed corners: power-up style codes, offset clamps, code clamps, holds.
    run_one(0, 20'h00123, 16'h0000, 0, 0, 10, 7, 2, 0, 0, 0, "R2");
    run_one(1, 20'h00456, 16'hBEEF, 0, 0, 10, 7, 2, 0, 0, 0, "R3");
    run_one(1, 20'h0A0A0, 16'h1234, 15, 0, 0, 0, 3, 4, 0, 0, "R3");
    run_one(0, 20'h0B0B1, 16'h0000, 0, 15, 0, 0, 15, 4, 0, 0, "R2");
    run_one(0, 20'h0C0C2, 16'h0000, 3, 2, 31, 31, 15, 20, 0, 0, "R4");
    run_one(1, 20'h0D0D3, 16'h5A5A, 2, 2, 31, 31, 15, 0, 0, 1, "R4");
    run_one(0, 20'h0E0E4, 16'h0000, 0, 1, 3, 3, 1, prev_t + 1, 1, 0, "R2");
    run_one(1, 20'h0F0F5, 16'h7777, 1, 0, 3, 3, 0, prev_t + 2, 0, 0, "R3");

    for (int i = 0; i < 60; i++) begin
      bit wr;
      int d;
      wr = 1'($urandom);
      if (last_poke || last_extra) d = prev_t + int'($urandom % 3);
      else d = int'($urandom % (prev_t + 3));
      run_one(wr, ADDR_W'($urandom), DATA_W'($urandom), int'($urandom % 16),
              int'($urandom % 16), int'($urandom % 32), int'($urandom % 32),
              int'($urandom % 16), d, ($urandom % 4) == 0, ($urandom % 3) == 0,
              wr ? "R3" : "R2");
    end
    // Final gap: a leftover ignored start must not create another access.
    begin
      bit stray;
      stray = 1'b0;
      repeat (prev_t + 4) begin
        @(negedge clk);
        if (!mem_cs_n) stray = 1'b1;
      end
      check(!stray, last_extra ? "R8" : "R9", "no access from ignored start", stray, 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule